// File: doc/BRIEF.md
# Flash Bus Write-Cycle Capture

This block is the clocked front end of a parallel flash-style command port. The active-low chip enable, write enable and output enable strobes arrive without any relation to the system clock. Each strobe passes through a two-flop synchroniser and a stability filter. The filter accepts a new level only after it has been seen for `FILT_CNT` consecutive clock samples, so short noise pulses never open a write. The address and data buses are sampled through a delay line that matches the strobe path. Captured values therefore reflect the bus as it stood just before the strobe edge that latched them.

A write opens while chip enable and write enable are both low and output enable is high. The address is taken when the second of chip enable and write enable falls. The data is taken when the first of the two rises. At that rising edge the block issues a one-cycle `wr_valid_o` pulse together with the captured address and data, for a downstream command interpreter to consume. After reset, writes stay locked out until all three strobes have been seen high at least once. Strobes held in the write state through power-up therefore cannot issue a command.

Top module: `flash_wr_capture`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `wr_valid_o` is 0 and `wr_addr_o`/`wr_data_o` are all zeros.
- R2: After reset, no write is accepted until the filtered chip enable, write enable and output enable have all been high in the same cycle. A write-enable rise while chip enable is still held low from reset produces no pulse.
- R3: A completed write cycle raises `wr_valid_o` exactly `FILT_CNT + 3` clock cycles after the first clock edge that samples the releasing strobe high.
- R4: `wr_addr_o` carries the address present when the later of chip enable and write enable fell. Address changes after that edge have no effect.
- R5: `wr_data_o` carries the data present when the earlier of chip enable and write enable rose. Data changes after that edge, while the other strobe is still low, have no effect.
- R6: A cycle controlled by chip enable, where write enable falls first and chip enable falls last and rises first, is captured the same way as a cycle controlled by write enable.
- R7: While output enable is low, chip enable and write enable pulses produce no write.
- R8: A strobe level that lasts fewer than `FILT_CNT` consecutive clock samples is ignored. A level that lasts exactly `FILT_CNT` samples is accepted.
- R9: If output enable goes low while a write cycle is open, that cycle is dropped. No pulse follows, even when the strobes are later released.
- R10: `wr_valid_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable strobe, active low, asynchronous |
| we_ni | input | 1 | Write enable strobe, active low, asynchronous |
| oe_ni | input | 1 | Output enable strobe, active low, asynchronous |
| addr_i | input | ADDR_W | Asynchronous address bus |
| data_i | input | DATA_W | Asynchronous data bus |
| wr_valid_o | output | 1 | One-cycle pulse when a write completes |
| wr_addr_o | output | ADDR_W | Captured write address |
| wr_data_o | output | DATA_W | Captured write data |

## Verification
Every write pulse is due `FILT_CNT + 3` cycles after the first clock edge that sees the releasing strobe. This comes from two synchroniser flops, `FILT_CNT - 1` filter counts, one cycle to detect the edge and the output register. The driver changes inputs only on falling clock edges. When it releases a strobe, it queues the expected address, data and due cycle. The monitor checks each pulse on a falling edge against the head of the queue, including the exact cycle. After each negative case, a quiet check confirms that no pulse appeared and that nothing is left waiting in the queue.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;
  typedef enum logic [1:0] {
    ST_LOCK   = 2'd0,  // waiting for all strobes inactive after reset
    ST_IDLE   = 2'd1,
    ST_ACTIVE = 2'd2,  // write cycle open
    ST_HOLD   = 2'd3   // aborted cycle, wait for strobe release
  } cyc_state_e;
endpackage

// File: rtl/fwc_strobe_filter.sv
module fwc_strobe_filter #(
  parameter int   FILT_CNT = 3,
  parameter logic INIT     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_CNT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CNT - 1);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= INIT;
      sync2_q <= INIT;
    end else begin
      sync1_q <= strobe_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= INIT;
      cnt_q   <= '0;
    end else if (sync2_q == level_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      level_o <= sync2_q;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // filtered level only moves towards a value the synchroniser already holds
  AST_FILT_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> ($past(sync2_q) == level_o)); // R8
endmodule

// File: rtl/fwc_bus_delay.sv
module fwc_bus_delay #(
  parameter int WIDTH = 37,
  parameter int DEPTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= '0;
        else if (i == 0) stage_q[i] <= bus_i;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign bus_o = stage_q[DEPTH-1];
endmodule

// File: rtl/fwc_cycle_ctrl.sv
module fwc_cycle_ctrl
  import flash_wr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_f_i,
  input  logic              we_f_i,
  input  logic              oe_f_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  cyc_state_e        state_q, state_d;
  logic              both_low, both_low_q, fire;
  logic [ADDR_W-1:0] addr_q;

  assign both_low = !ce_f_i && !we_f_i;
  assign fire     = (state_q == ST_ACTIVE) && oe_f_i && !both_low;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOCK:   if (ce_f_i && we_f_i && oe_f_i) state_d = ST_IDLE;
      ST_IDLE:   if (both_low && oe_f_i) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (!oe_f_i)       state_d = both_low ? ST_HOLD : ST_IDLE;
        else if (!both_low) state_d = ST_IDLE;
      end
      ST_HOLD:   if (!both_low) state_d = ST_IDLE;
      default:   state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_LOCK;
      both_low_q <= 1'b0;
      addr_q     <= '0;
    end else begin
      state_q    <= state_d;
      both_low_q <= both_low;
      // later of the two falling edges completes the low pair
      if (both_low && !both_low_q) addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= fire;
      if (fire) begin
        wr_addr_o <= addr_q;
        wr_data_o <= data_i;
      end
    end
  end

  AST_LOCK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK) |=> !wr_valid_o); // R2
  AST_WRITE_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(oe_f_i)); // R7
  AST_ABORT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |=> !wr_valid_o); // R9
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && $past(state_q == ST_ACTIVE)) |-> $stable(addr_q)); // R4
endmodule

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int FILT_CNT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int NSTB    = 3;
  localparam int BUS_W   = ADDR_W + DATA_W;
  // sync(2) + filter(FILT_CNT-1) + edge detect, plus one to pick the pre-edge sample
  localparam int BUS_DLY = FILT_CNT + 3;

  logic [NSTB-1:0]  stb_raw, stb_f;
  logic [BUS_W-1:0] bus_d;

  assign stb_raw = {oe_ni, we_ni, ce_ni};

  generate
    for (genvar i = 0; i < NSTB; i++) begin : g_filt
      fwc_strobe_filter #(.FILT_CNT(FILT_CNT), .INIT(1'b0)) u_filt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (stb_raw[i]),
        .level_o  (stb_f[i])
      );
    end
  endgenerate

  fwc_bus_delay #(.WIDTH(BUS_W), .DEPTH(BUS_DLY)) u_bus_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bus_i  ({addr_i, data_i}),
    .bus_o  (bus_d)
  );

  fwc_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_f_i     (stb_f[0]),
    .we_f_i     (stb_f[1]),
    .oe_f_i     (stb_f[2]),
    .addr_i     (bus_d[BUS_W-1:DATA_W]),
    .data_i     (bus_d[DATA_W-1:0]),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R10
endmodule

// File: tb/flash_wr_capture_tb.sv
`timescale 1ns/1ps
module flash_wr_capture_tb;
  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;
  localparam int FILT_CNT = 3;
  localparam int LAT = FILT_CNT + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n, we_n, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic wr_valid_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    int                due;
    string             req;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0, unexp = 0;
  logic prev_valid = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CNT(FILT_CNT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // call on the negedge where the releasing strobe is driven
  task automatic expect_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, string req);
    exp_t e;
    e.a = a; e.d = d; e.due = cyc + LAT; e.req = req;
    q.push_back(e);
  endtask

  task automatic chk_quiet(int unexp_before, string req);
    checks++;
    if (unexp != unexp_before || q.size() != 0) begin
      errors++;
      $display("FAIL %s: unexpected pulses %0d pending %0d, expected 0 and 0",
               req, unexp - unexp_before, q.size());
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_valid) begin
        checks++;
        if (wr_valid_o) begin
          errors++;
          $display("FAIL R10: wr_valid_o high two cycles, actual 1 expected 0");
        end
      end
      if (wr_valid_o) begin
        if (q.size() == 0) begin
          unexp++;
        end else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (wr_addr_o !== e.a || wr_data_o !== e.d || cyc != e.due) begin
            errors++;
            $display("FAIL %s: addr %h data %h cycle %0d, expected addr %h data %h cycle %0d",
                     e.req, wr_addr_o, wr_data_o, cyc, e.a, e.d, e.due);
          end
        end
      end else if (q.size() != 0 && cyc > q[0].due) begin
        exp_t e;
        e = q.pop_front();
        checks++; errors++;
        $display("FAIL %s: no pulse by cycle %0d, expected addr %h data %h", e.req, cyc, e.a, e.d);
      end
      prev_valid = wr_valid_o;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int u;
    // power up with a write held on the strobes
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = '0; data = '0;
    idle(4);
    checks++;
    if (wr_valid_o !== 1'b0 || wr_addr_o !== '0 || wr_data_o !== '0) begin
      errors++;
      $display("FAIL R1: in reset valid %b addr %h data %h, expected 0 0 0", wr_valid_o, wr_addr_o, wr_data_o);
    end
    rst_n = 1'b1;
    idle(1);
    checks++;
    if (wr_valid_o !== 1'b0 || wr_addr_o !== '0 || wr_data_o !== '0) begin
      errors++;
      $display("FAIL R1: after reset valid %b addr %h data %h, expected 0 0 0", wr_valid_o, wr_addr_o, wr_data_o);
    end

    // R2: write enable rises while still locked
    u = unexp;
    addr = 21'h0aaaa; data = 16'h1111;
    idle(10); we_n = 1'b1; idle(12); ce_n = 1'b1; idle(15);
    chk_quiet(u, "R2");

    // R3: plain writes with varied values
    for (int i = 0; i < 3; i++) begin
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      a = ADDR_W'(21'h15555 ^ (i * 21'h0f0f3));
      d = DATA_W'(16'ha5c3 + i * 16'h1357);
      addr = a; data = d;
      idle(6); ce_n = 1'b0; idle(5); we_n = 1'b0; idle(8);
      expect_write(a, d, "R3");
      we_n = 1'b1; idle(6); ce_n = 1'b1; idle(14);
    end

    // R4 and R5: address at later fall (we), data at earlier rise (we)
    addr = 21'h1f000; data = 16'h0bad;
    idle(6); ce_n = 1'b0; idle(6);
    addr = 21'h02468; idle(6); we_n = 1'b0; idle(10);
    addr = 21'h1ffff; data = 16'hbeef; idle(6);
    expect_write(21'h02468, 16'hbeef, "R4/R5");
    we_n = 1'b1; idle(6);
    data = 16'hdead; idle(6); ce_n = 1'b1; idle(14);

    // R6: chip enable controlled cycle
    addr = 21'h00123; data = 16'h0000;
    idle(6); we_n = 1'b0; idle(6);
    addr = 21'h13579; idle(6); ce_n = 1'b0; idle(10);
    addr = 21'h00000; data = 16'h7e57; idle(6);
    expect_write(21'h13579, 16'h7e57, "R6");
    ce_n = 1'b1; idle(6);
    data = 16'h5555; idle(6); we_n = 1'b1; idle(14);

    // R7: output enable low inhibits
    u = unexp;
    oe_n = 1'b0; idle(6); ce_n = 1'b0; idle(4); we_n = 1'b0; idle(10);
    we_n = 1'b1; idle(6); ce_n = 1'b1; idle(6); oe_n = 1'b1; idle(16);
    chk_quiet(u, "R7");

    // R8: glitch one sample short of FILT_CNT is rejected
    u = unexp;
    addr = 21'h0dddd; data = 16'h4444;
    idle(6); ce_n = 1'b0; idle(8);
    we_n = 1'b0; idle(FILT_CNT - 1); we_n = 1'b1; idle(14);
    ce_n = 1'b1; idle(14);
    chk_quiet(u, "R8");
    // exactly FILT_CNT samples accepted
    idle(2); ce_n = 1'b0; idle(8);
    we_n = 1'b0; idle(FILT_CNT);
    expect_write(21'h0dddd, 16'h4444, "R8");
    we_n = 1'b1; idle(14); ce_n = 1'b1; idle(14);

    // R9: output enable drops inside an open cycle
    u = unexp;
    addr = 21'h0abcd; data = 16'h9999;
    idle(6); ce_n = 1'b0; idle(4); we_n = 1'b0; idle(10);
    oe_n = 1'b0; idle(10); we_n = 1'b1; idle(4); ce_n = 1'b1; idle(6);
    oe_n = 1'b1; idle(16);
    chk_quiet(u, "R9");

    // normal write after abort still works (R3)
    addr = 21'h1c0de; data = 16'hcafe;
    idle(6); ce_n = 1'b0; we_n = 1'b0; idle(10);
    expect_write(21'h1c0de, 16'hcafe, "R3");
    ce_n = 1'b1; we_n = 1'b1; idle(16);
    u = unexp;
    chk_quiet(u, "R10");

    summary();
    $finish;
  end
endmodule